// File: doc/BRIEF.md
# Banked Nibble-Register Real-Time Clock

This block is a calendar clock that a host reaches as sixteen 4-bit locations on a plain synchronous bus with address, write data, a write strobe, a read strobe and read data. The upper three locations are always the mode, test and control registers. The lower thirteen form a window whose contents depend on a 2-bit bank field in the mode register. One bank shows the BCD time and date digits. One shows the alarm digits and the 12/24-hour and leap-year settings. The last two are plain scratch nibbles.

A tick-enable input stands in for the crystal. A parameterised prescaler turns it into 16 Hz and 1 Hz events. The 1 Hz event advances the digits with full calendar carry, covering month lengths and a two-bit leap counter. Clearing the timer-enable bit in the mode register freezes the digits, so the host can read or load a coherent time. The control register clears the divider and the alarm, and gates the two pulse outputs.

Top module: `nibble_rtc`

## Requirements
- R1: A read strobe in a cycle captures the addressed nibble, which appears on `rdata` from the next clock edge and holds until the next read strobe. Address 0xD returns the mode register in every bank. Address 0xE reads as 0 and ignores writes.
- R2: Mode bits [1:0] select the bank behind addresses 0x0–0xC: 00 selects time, 01 selects alarm/configuration, 10 selects scratch bank A and 11 selects scratch bank B.
- R3: While mode bit 3 (timer enable) is 0, the time digits do not advance. Host writes to the time bank still load them.
- R4: Time bank digits: 0x0/0x1 second units/tens, 0x2/0x3 minute units/tens. Seconds and minutes each wrap 59→00 and carry into the next field.
- R5: Hours sit at 0x4 (units) and 0x5 (tens). With bank-01 address 0xA bit 0 set to 1 (24-hour mode), hours wrap 23→00 and carry a day. With that bit at 0 (12-hour mode), bit 1 of the hour tens is PM. The sequence is 11→12 with PM toggled, then 12→01. The change from 11 PM to 12 AM carries a day.
- R6: Day of week (0x6) wraps 6→0 on each day carry. Day of month (0x7 units, 0x8 tens) wraps by month length, and February has 29 days when the leap counter (bank-01 address 0xB, 2 bits) is 0. Month (0x9 units, 0xA tens) wraps 12→01 into the year (0xB units, 0xC tens), which wraps 99→00. Each year carry adds 1 to the leap counter modulo 4.
- R7: Bank-01 addresses 0x2–0x8 hold alarm digits laid out like the time bank. The alarm flag sets one cycle after a second advance when mode bit 2 (alarm enable) is 1 and all seven alarm digits equal the time digits. The flag stays set until a control-register (0xF) write with bit 0 set, which also clears the alarm digits.
- R8: A 16 Hz event occurs every `TICKS_PER_16HZ` tick-enable cycles and a 1 Hz event on every `SUB_PER_SEC`-th 16 Hz event. A control write with bit 1 set clears both divider stages.
- R9: Control bit 3 enables `pulse_1hz` and bit 2 enables `pulse_16hz`. Each pulse is one cycle long, registered one edge after its event. Every control write reloads both enables, and reading 0xF returns {bit3, bit2, 0, 0}.
- R10: Each scratch bank keeps exactly the nibble last written at each of its thirteen addresses, independent of the other scratch bank and of the time bank.
- R11: After reset, the mode register is 0x8, the time is 00:00:00 on day 01, month 01, year 00 with weekday 0, 24-hour mode is on, the leap counter is 0, and the alarm flag and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler count enable (crystal stand-in) |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Read data, valid the cycle after the strobe |
| alarm_flag | output | 1 | Sticky alarm match flag |
| pulse_1hz | output | 1 | One-cycle pulse per second when enabled |
| pulse_16hz | output | 1 | One-cycle pulse per 16 Hz event when enabled |

## Verification
The hardest states to reach are the carries that run through every digit at once: 23:59:59 on the last day of a month, February in and out of a leap year, and 31 December 99. Waiting for them in real time would take far too long. The stimulus instead freezes the clock with timer enable cleared and loads each digit through the time bank. It then clears the divider so the next second arrives after a known tick count, and lets exactly one second run. The 12-hour PM transitions, the alarm-enable gate and the sticky alarm flag are reached the same way by loading a time one second before the event.

// File: rtl/nibble_rtc_pkg.sv
package nibble_rtc_pkg;
  localparam int NIB_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int N_BANKED = 13;
  localparam int RAM_IDX_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    BANK_TIME  = 2'b00,
    BANK_ALARM = 2'b01,
    BANK_RAM_A = 2'b10,
    BANK_RAM_B = 2'b11
  } bank_e;

  // time bank digit positions (alarm bank reuses 2..8)
  localparam logic [ADDR_W-1:0] A_SEC_U = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC_T = 4'h1;
  localparam logic [ADDR_W-1:0] A_MIN_U = 4'h2;
  localparam logic [ADDR_W-1:0] A_MIN_T = 4'h3;
  localparam logic [ADDR_W-1:0] A_HR_U  = 4'h4;
  localparam logic [ADDR_W-1:0] A_HR_T  = 4'h5;
  localparam logic [ADDR_W-1:0] A_WDAY  = 4'h6;
  localparam logic [ADDR_W-1:0] A_DAY_U = 4'h7;
  localparam logic [ADDR_W-1:0] A_DAY_T = 4'h8;
  localparam logic [ADDR_W-1:0] A_MON_U = 4'h9;
  localparam logic [ADDR_W-1:0] A_MON_T = 4'hA;
  localparam logic [ADDR_W-1:0] A_YR_U  = 4'hB;
  localparam logic [ADDR_W-1:0] A_YR_T  = 4'hC;
  // configuration bank
  localparam logic [ADDR_W-1:0] A_H24   = 4'hA;
  localparam logic [ADDR_W-1:0] A_LEAP  = 4'hB;
  // common locations
  localparam logic [ADDR_W-1:0] A_MODE  = 4'hD;
  localparam logic [ADDR_W-1:0] A_TEST  = 4'hE;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'hF;

  localparam int MODE_TIMER_BIT = 3;
  localparam int MODE_ALARM_BIT = 2;
  localparam int CTRL_1HZ_BIT   = 3;
  localparam int CTRL_16HZ_BIT  = 2;
  localparam int CTRL_DIV_BIT   = 1;
  localparam int CTRL_ALM_BIT   = 0;

  localparam logic [NIB_W-1:0] MODE_RST = 4'h8;

  typedef logic [N_BANKED-1:0][NIB_W-1:0] digits_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_16HZ = 2048,
  parameter int SUB_PER_SEC    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic ev16,
  output logic ev1
);
  localparam int CW = (TICKS_PER_16HZ > 1) ? $clog2(TICKS_PER_16HZ) : 1;
  localparam int SW = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;

  logic [CW-1:0] c16;
  logic [SW-1:0] c1;

  assign ev16 = tick && (c16 == CW'(TICKS_PER_16HZ - 1));
  assign ev1  = ev16 && (c1 == SW'(SUB_PER_SEC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c16 <= '0;
      c1  <= '0;
    end else if (tick) begin
      c16 <= ev16 ? '0 : c16 + 1'b1;
      if (ev16) c1 <= ev1 ? '0 : c1 + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import nibble_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr_digit,
  input  logic              wr_h24,
  input  logic              wr_leap,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0]  wdata,
  output digits_t           dig,
  output logic              h24,
  output logic [1:0]        leap
);
  digits_t    nx;
  logic [1:0] nleap;
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] last_day;

  // last day of the current month as two BCD digits
  always_comb begin
    case ({dig[A_MON_T], dig[A_MON_U]})
      8'h02:                      last_day = (leap == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    nx    = dig;
    nleap = leap;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (adv) begin
      // seconds
      if (dig[A_SEC_U] >= 4'd9) begin
        nx[A_SEC_U] = 4'd0;
        if (dig[A_SEC_T] >= 4'd5) begin
          nx[A_SEC_T] = 4'd0;
          c_min = 1'b1;
        end else nx[A_SEC_T] = dig[A_SEC_T] + 4'd1;
      end else nx[A_SEC_U] = dig[A_SEC_U] + 4'd1;
      // minutes
      if (c_min) begin
        if (dig[A_MIN_U] >= 4'd9) begin
          nx[A_MIN_U] = 4'd0;
          if (dig[A_MIN_T] >= 4'd5) begin
            nx[A_MIN_T] = 4'd0;
            c_hr = 1'b1;
          end else nx[A_MIN_T] = dig[A_MIN_T] + 4'd1;
        end else nx[A_MIN_U] = dig[A_MIN_U] + 4'd1;
      end
      // hours
      if (c_hr) begin
        if (h24) begin
          if (dig[A_HR_T] >= 4'd2 && dig[A_HR_U] >= 4'd3) begin
            nx[A_HR_U] = 4'd0;
            nx[A_HR_T] = 4'd0;
            c_day = 1'b1;
          end else if (dig[A_HR_U] >= 4'd9) begin
            nx[A_HR_U] = 4'd0;
            nx[A_HR_T] = dig[A_HR_T] + 4'd1;
          end else nx[A_HR_U] = dig[A_HR_U] + 4'd1;
        end else begin
          // tens bit 0 = ten hours, bit 1 = PM
          if (dig[A_HR_T][0] && dig[A_HR_U] == 4'd1) begin
            nx[A_HR_U] = 4'd2;
            nx[A_HR_T] = {2'b00, ~dig[A_HR_T][1], 1'b1};
            c_day = dig[A_HR_T][1];
          end else if (dig[A_HR_T][0] && dig[A_HR_U] >= 4'd2) begin
            nx[A_HR_U] = 4'd1;
            nx[A_HR_T] = {2'b00, dig[A_HR_T][1], 1'b0};
          end else if (dig[A_HR_U] >= 4'd9) begin
            nx[A_HR_U] = 4'd0;
            nx[A_HR_T] = {2'b00, dig[A_HR_T][1], 1'b1};
          end else nx[A_HR_U] = dig[A_HR_U] + 4'd1;
        end
      end
      // day of week and day of month
      if (c_day) begin
        nx[A_WDAY] = (dig[A_WDAY] >= 4'd6) ? 4'd0 : dig[A_WDAY] + 4'd1;
        if ({dig[A_DAY_T], dig[A_DAY_U]} >= last_day) begin
          nx[A_DAY_U] = 4'd1;
          nx[A_DAY_T] = 4'd0;
          c_mon = 1'b1;
        end else if (dig[A_DAY_U] >= 4'd9) begin
          nx[A_DAY_U] = 4'd0;
          nx[A_DAY_T] = dig[A_DAY_T] + 4'd1;
        end else nx[A_DAY_U] = dig[A_DAY_U] + 4'd1;
      end
      // month
      if (c_mon) begin
        if ({dig[A_MON_T], dig[A_MON_U]} >= 8'h12) begin
          nx[A_MON_U] = 4'd1;
          nx[A_MON_T] = 4'd0;
          c_yr = 1'b1;
        end else if (dig[A_MON_U] >= 4'd9) begin
          nx[A_MON_U] = 4'd0;
          nx[A_MON_T] = dig[A_MON_T] + 4'd1;
        end else nx[A_MON_U] = dig[A_MON_U] + 4'd1;
      end
      // year and leap counter
      if (c_yr) begin
        nleap = leap + 2'd1;
        if (dig[A_YR_U] >= 4'd9) begin
          nx[A_YR_U] = 4'd0;
          nx[A_YR_T] = (dig[A_YR_T] >= 4'd9) ? 4'd0 : dig[A_YR_T] + 4'd1;
        end else nx[A_YR_U] = dig[A_YR_U] + 4'd1;
      end
    end
  end

  // host writes take precedence over the advance in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      dig          <= '0;
      dig[A_DAY_U] <= 4'd1;
      dig[A_MON_U] <= 4'd1;
      h24          <= 1'b1;
      leap         <= 2'd0;
    end else begin
      dig  <= nx;
      leap <= nleap;
      if (wr_digit && waddr < ADDR_W'(N_BANKED)) dig[waddr] <= wdata;
      if (wr_h24)  h24  <= wdata[0];
      if (wr_leap) leap <= wdata[1:0];
    end
  end
endmodule

// File: rtl/rtc_nibble_ram.sv
module rtc_nibble_ram #(
  parameter int DATA_W = 4,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import nibble_rtc_pkg::*;
#(
  parameter int TICKS_PER_16HZ = 2048,
  parameter int SUB_PER_SEC    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic [3:0]  addr,
  input  logic [3:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [3:0]  rdata,
  output logic        alarm_flag,
  output logic        pulse_1hz,
  output logic        pulse_16hz
);
  logic [NIB_W-1:0] mode_q;
  logic             en_1hz, en_16hz;
  digits_t          cal_dig;
  digits_t          alm_dig;
  logic             h24;
  logic [1:0]       leap;
  logic             ev16, ev1, adv, sec_ev_q;
  logic             alarm_match;
  logic [NIB_W-1:0] rd_next, rd_reg, ram_q;
  logic             rd_sel_ram;
  bank_e            bank;

  assign bank = bank_e'(mode_q[1:0]);

  logic is_banked, is_alarm_digit;
  assign is_banked      = addr < ADDR_W'(N_BANKED);
  assign is_alarm_digit = addr >= A_MIN_U && addr <= A_DAY_T;

  logic wr_time, wr_alm, wr_h24, wr_leap, wr_mode, wr_ctrl, ram_we, ram_rd;
  assign wr_time = wr_en && is_banked && bank == BANK_TIME;
  assign wr_alm  = wr_en && is_alarm_digit && bank == BANK_ALARM;
  assign wr_h24  = wr_en && addr == A_H24 && bank == BANK_ALARM;
  assign wr_leap = wr_en && addr == A_LEAP && bank == BANK_ALARM;
  assign wr_mode = wr_en && addr == A_MODE;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign ram_we  = wr_en && is_banked && mode_q[1];
  assign ram_rd  = rd_en && is_banked && mode_q[1];

  logic div_clr, alm_clr;
  assign div_clr = wr_ctrl && wdata[CTRL_DIV_BIT];
  assign alm_clr = wr_ctrl && wdata[CTRL_ALM_BIT];

  assign adv = ev1 && mode_q[MODE_TIMER_BIT];

  rtc_prescaler #(
    .TICKS_PER_16HZ(TICKS_PER_16HZ),
    .SUB_PER_SEC   (SUB_PER_SEC)
  ) u_presc (
    .clk (clk),
    .rst (rst),
    .clr (div_clr),
    .tick(tick_en),
    .ev16(ev16),
    .ev1 (ev1)
  );

  rtc_calendar u_cal (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .wr_digit(wr_time),
    .wr_h24  (wr_h24),
    .wr_leap (wr_leap),
    .waddr   (addr),
    .wdata   (wdata),
    .dig     (cal_dig),
    .h24     (h24),
    .leap    (leap)
  );

  rtc_nibble_ram #(
    .DATA_W(NIB_W),
    .IDX_W (RAM_IDX_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr({mode_q[0], addr}),
    .wdata(wdata),
    .re   (ram_rd),
    .raddr({mode_q[0], addr}),
    .q    (ram_q)
  );

  // mode and control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_RST;
      en_1hz  <= 1'b0;
      en_16hz <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ctrl) begin
        en_1hz  <= wdata[CTRL_1HZ_BIT];
        en_16hz <= wdata[CTRL_16HZ_BIT];
      end
    end
  end

  // alarm digits
  always_ff @(posedge clk) begin
    if (rst || alm_clr) alm_dig <= '0;
    else if (wr_alm) alm_dig[addr] <= wdata;
  end

  always_comb begin
    alarm_match = 1'b1;
    for (int i = int'(A_MIN_U); i <= int'(A_DAY_T); i++)
      if (alm_dig[i] != cal_dig[i]) alarm_match = 1'b0;
  end

  // compare one cycle after the advance, against the new time
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_ev_q   <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      sec_ev_q <= adv;
      if (alm_clr) alarm_flag <= 1'b0;
      else if (sec_ev_q && mode_q[MODE_ALARM_BIT] && alarm_match) alarm_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_1hz  <= 1'b0;
      pulse_16hz <= 1'b0;
    end else begin
      pulse_1hz  <= ev1 && en_1hz;
      pulse_16hz <= ev16 && en_16hz;
    end
  end

  // read path
  always_comb begin
    rd_next = '0;
    if (addr == A_MODE) rd_next = mode_q;
    else if (addr == A_CTRL) rd_next = {en_1hz, en_16hz, 2'b00};
    else if (addr == A_TEST) rd_next = '0;
    else if (bank == BANK_TIME) rd_next = cal_dig[addr];
    else if (bank == BANK_ALARM) begin
      if (is_alarm_digit)      rd_next = alm_dig[addr];
      else if (addr == A_H24)  rd_next = {3'b000, h24};
      else if (addr == A_LEAP) rd_next = {2'b00, leap};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg     <= '0;
      rd_sel_ram <= 1'b0;
    end else if (rd_en) begin
      rd_reg     <= rd_next;
      rd_sel_ram <= is_banked && mode_q[1];
    end
  end

  assign rdata = rd_sel_ram ? ram_q : rd_reg;
endmodule

// File: rtl/nibble_rtc_checker.sv
module nibble_rtc_checker
  import nibble_rtc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [3:0] wdata,
  input logic [3:0] rdata,
  input logic       alarm_flag,
  input logic       pulse_1hz,
  input logic       pulse_16hz,
  input logic [3:0] mode_q,
  input logic       en_1hz,
  input logic       en_16hz,
  input digits_t    dig
);
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R1

  AST_FROZEN_TIME: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[MODE_TIMER_BIT] && !wr_en) |=> $stable(dig)); // R3

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !(wr_en && addr == A_CTRL && wdata[CTRL_ALM_BIT])) |=> alarm_flag); // R7

  AST_ALARM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(mode_q[MODE_ALARM_BIT])); // R7

  AST_1HZ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_1hz |=> !pulse_1hz); // R8

  AST_1HZ_GATED: assert property (@(posedge clk) disable iff (rst)
    pulse_1hz |-> $past(en_1hz)); // R9

  AST_16HZ_GATED: assert property (@(posedge clk) disable iff (rst)
    pulse_16hz |-> $past(en_16hz)); // R9
endmodule

bind nibble_rtc nibble_rtc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .alarm_flag(alarm_flag),
  .pulse_1hz (pulse_1hz),
  .pulse_16hz(pulse_16hz),
  .mode_q    (mode_q),
  .en_1hz    (en_1hz),
  .en_16hz   (en_16hz),
  .dig       (cal_dig)
);

// File: tb/nibble_rtc_bench.sv
module nibble_rtc_bench;
  localparam int TP = 2;
  localparam int SUBS = 16;
  localparam int CYC_PER_SEC = TP * SUBS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [3:0] wdata = 4'h0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] rdata;
  logic       alarm_flag, pulse_1hz, pulse_16hz;

  always #5 clk = ~clk;

  nibble_rtc #(.TICKS_PER_16HZ(TP), .SUB_PER_SEC(SUBS)) u_nibble_rtc (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .alarm_flag(alarm_flag),
    .pulse_1hz(pulse_1hz), .pulse_16hz(pulse_16hz)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // scoreboard monitor: pops one expected nibble per read strobe
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() == 0) check(int'(rdata), -1, "scoreboard underflow");
      else check(int'(rdata), int'(exp_q.pop_front()), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // clear divider, then let exactly n seconds of ticks through
  task automatic run_secs(input int n);
    wr(4'hF, 4'h2);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n * CYC_PER_SEC) @(negedge clk);
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_hms(input logic [3:0] ht, hu, mt, mu, st, su);
    wr(4'h0, su); wr(4'h1, st); wr(4'h2, mu);
    wr(4'h3, mt); wr(4'h4, hu); wr(4'h5, ht);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(4'hD, 4'h8, "R11 mode reset");
    rd(4'h0, 4'h0, "R11 seconds reset");
    rd(4'h7, 4'h1, "R11 day reset");
    rd(4'h9, 4'h1, "R11 month reset");
    rd(4'hF, 4'h0, "R11 control reset");
    check(int'(alarm_flag), 0, "R11 alarm flag reset");
    check(int'(pulse_1hz | pulse_16hz), 0, "R11 pulses reset");

    // scratch banks
    wr(4'hD, 4'hA); wr(4'h3, 4'h5); wr(4'hC, 4'h7);
    wr(4'hD, 4'hB); wr(4'h3, 4'hC);
    rd(4'h3, 4'hC, "R10 bank B nibble");
    rd(4'hD, 4'hB, "R1 mode visible in bank B");
    wr(4'hD, 4'hA);
    rd(4'h3, 4'h5, "R10 bank A kept");
    rd(4'hC, 4'h7, "R10 bank A top address");
    wr(4'hD, 4'h8);
    rd(4'h3, 4'h0, "R2 time bank untouched by scratch writes");
    wr(4'hE, 4'h9);
    rd(4'hE, 4'h0, "R1 test location reads zero");

    // freeze
    wr(4'hD, 4'h0);
    run_secs(2);
    rd(4'h0, 4'h0, "R3 frozen seconds");

    // 23:59:58 on 28 Feb 00, weekday 6, leap counter 0
    set_hms(4'h2, 4'h3, 4'h5, 4'h9, 4'h5, 4'h8);
    wr(4'h7, 4'h8); wr(4'h8, 4'h2); wr(4'h9, 4'h2); wr(4'hA, 4'h0);
    wr(4'hB, 4'h0); wr(4'hC, 4'h0); wr(4'h6, 4'h6);
    wr(4'hD, 4'h8);
    run_secs(2);
    rd(4'h0, 4'h0, "R4 sec units wrap");
    rd(4'h1, 4'h0, "R4 sec tens wrap");
    rd(4'h2, 4'h0, "R4 min units wrap");
    rd(4'h3, 4'h0, "R4 min tens wrap");
    rd(4'h4, 4'h0, "R5 24h hour units wrap");
    rd(4'h5, 4'h0, "R5 24h hour tens wrap");
    rd(4'h6, 4'h0, "R6 weekday 6 to 0");
    rd(4'h7, 4'h9, "R6 leap Feb 29 units");
    rd(4'h8, 4'h2, "R6 leap Feb 29 tens");
    rd(4'h9, 4'h2, "R6 still February");

    // 29 Feb -> 1 Mar
    wr(4'hD, 4'h0);
    set_hms(4'h2, 4'h3, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h7, 4'h1, "R6 Feb 29 wraps to day 1");
    rd(4'h9, 4'h3, "R6 March after leap Feb");

    // non-leap: 28 Feb -> 1 Mar
    wr(4'hD, 4'h1); wr(4'hB, 4'h1);
    rd(4'hB, 4'h1, "R6 leap counter loaded");
    wr(4'hD, 4'h0);
    wr(4'h7, 4'h8); wr(4'h8, 4'h2); wr(4'h9, 4'h2); wr(4'hA, 4'h0);
    set_hms(4'h2, 4'h3, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h7, 4'h1, "R6 Feb 28 wraps when leap counter nonzero");
    rd(4'h8, 4'h0, "R6 day tens after wrap");
    rd(4'h9, 4'h3, "R6 March after plain Feb");

    // 31 Dec 99 -> 1 Jan 00
    wr(4'hD, 4'h0);
    wr(4'h7, 4'h1); wr(4'h8, 4'h3); wr(4'h9, 4'h2); wr(4'hA, 4'h1);
    wr(4'hB, 4'h9); wr(4'hC, 4'h9);
    set_hms(4'h2, 4'h3, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h9, 4'h1, "R6 month units wrap");
    rd(4'hA, 4'h0, "R6 month tens wrap");
    rd(4'hB, 4'h0, "R6 year units wrap");
    rd(4'hC, 4'h0, "R6 year tens wrap");
    wr(4'hD, 4'h9);
    rd(4'hB, 4'h2, "R6 leap counter increments");

    // 12-hour mode
    wr(4'hA, 4'h0);
    rd(4'hA, 4'h0, "R5 12h selected");
    wr(4'hD, 4'h0);
    set_hms(4'h1, 4'h1, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h4, 4'h2, "R5 11AM to 12PM units");
    rd(4'h5, 4'h3, "R5 11AM to 12PM tens with PM");
    wr(4'hD, 4'h0);
    set_hms(4'h3, 4'h2, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h4, 4'h1, "R5 12PM to 1PM units");
    rd(4'h5, 4'h2, "R5 12PM to 1PM tens");
    wr(4'hD, 4'h0);
    set_hms(4'h3, 4'h1, 4'h5, 4'h9, 4'h5, 4'h9);
    wr(4'h7, 4'h0); wr(4'h8, 4'h1);
    wr(4'hD, 4'h8);
    run_secs(1);
    rd(4'h4, 4'h2, "R5 11PM to 12AM units");
    rd(4'h5, 4'h1, "R5 11PM to 12AM tens");
    rd(4'h7, 4'h1, "R5 midnight carries a day");
    wr(4'hD, 4'h1); wr(4'hA, 4'h1);

    // alarm at 00:05:00 on day 01, weekday 3
    wr(4'hD, 4'h0);
    set_hms(4'h0, 4'h0, 4'h0, 4'h4, 4'h5, 4'h9);
    wr(4'h7, 4'h1); wr(4'h8, 4'h0); wr(4'h6, 4'h3);
    wr(4'hD, 4'h1);
    wr(4'h2, 4'h5); wr(4'h3, 4'h0); wr(4'h4, 4'h0); wr(4'h5, 4'h0);
    wr(4'h6, 4'h3); wr(4'h7, 4'h1); wr(4'h8, 4'h0);
    rd(4'h2, 4'h5, "R7 alarm digit stored");
    wr(4'hD, 4'h8);
    run_secs(1);
    check(int'(alarm_flag), 0, "R7 match ignored with alarm disabled");
    wr(4'hD, 4'h0);
    set_hms(4'h0, 4'h0, 4'h0, 4'h4, 4'h5, 4'h9);
    wr(4'hD, 4'hC);
    run_secs(1);
    check(int'(alarm_flag), 1, "R7 alarm flag on match");
    run_secs(1);
    check(int'(alarm_flag), 1, "R7 alarm flag sticky");
    wr(4'hF, 4'h1);
    @(negedge clk);
    check(int'(alarm_flag), 0, "R7 control bit0 clears flag");
    wr(4'hD, 4'hD);
    rd(4'h2, 4'h0, "R7 control bit0 clears alarm digits");
    wr(4'hD, 4'h0);

    // pulses
    wr(4'hF, 4'hE);
    rd(4'hF, 4'hC, "R9 enables read back");
    begin
      int p1 = 0, p16 = 0, first1 = 0;
      @(negedge clk);
      tick_en = 1'b1;
      for (int k = 1; k <= 2 * CYC_PER_SEC; k++) begin
        @(negedge clk);
        if (pulse_16hz) p16++;
        if (pulse_1hz) begin
          p1++;
          if (first1 == 0) first1 = k;
        end
      end
      tick_en = 1'b0;
      check(p16, 2 * SUBS, "R8 16Hz pulse count");
      check(p1, 2, "R8 1Hz pulse count");
      check(first1, CYC_PER_SEC, "R8 first 1Hz pulse after divider clear");
    end
    wr(4'hF, 4'h2);
    begin
      int pn = 0;
      @(negedge clk);
      tick_en = 1'b1;
      for (int k = 1; k <= 2 * CYC_PER_SEC; k++) begin
        @(negedge clk);
        if (pulse_16hz || pulse_1hz) pn++;
      end
      tick_en = 1'b0;
      check(pn, 0, "R9 pulses gated off");
    end

    repeat (4) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule